// File: doc/BRIEF.md
# Precision Time-of-Day Counter with Fine Frequency Trim

This block keeps a running time of day as a seconds count and a nanoseconds count, for use by timestamping logic elsewhere in the chip. On every counting event the nanoseconds value grows by a programmable subsecond step. It wraps at one second in decimal nanoseconds and carries into the seconds count. Two rate modes exist. In coarse mode the step is applied on every enabled clock. In fine mode a wide accumulator adds a trim word on each enabled clock, and only its carry-out applies a step. Changing the trim word therefore tunes the counter's frequency in very small amounts.

Software changes the time through a pair of shadow words and three one-shot command flags. One flag loads the time outright. One adds or subtracts an offset; bit 31 of the shadow nanoseconds word selects subtraction. One copies a new trim word into the accumulator. Each flag reads back as pending until the hardware has acted, and then it clears by itself.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the seconds and nanoseconds outputs are zero, the step strobe is low and all three pending flags are low.
- R2: In coarse mode (`fine_i`=0) with `enable_i` high and no command executing, every clock edge adds `sub_inc_i` to the nanoseconds and raises `tick_o` for the following cycle.
- R3: The nanoseconds output never reaches 1,000,000,000. A step that would reach or pass it subtracts 10^9 and adds one second.
- R4: In fine mode (`fine_i`=1) a 32-bit accumulator adds the loaded trim word on each enabled edge, and a step happens only on an edge where that sum carries out. A trim of 0x8000_0000 gives one step per two edges; 0x4000_0000 gives one per four.
- R5: While `enable_i` is low, time holds, `tick_o` stays low and the accumulator does not advance.
- R6: A pulse on `init_set_i` raises `init_pending_o` at the next edge. At the edge after that, the seconds take `shadow_sec_i`, the nanoseconds take `shadow_ns_i[29:0]`, and the flag clears.
- R7: An update with `shadow_ns_i[31]`=0 adds the shadow seconds and `shadow_ns_i[30:0]` to the running time, carrying one second when the nanoseconds sum reaches 10^9.
- R8: An update with `shadow_ns_i[31]`=1 subtracts. The shadow nanoseconds field then holds 10^9 minus the magnitude. A nanoseconds result that would fall below zero borrows one second.
- R9: When init and update are pending on the same edge, init executes first. Update stays pending and executes on the next edge against the freshly loaded time.
- R10: On an edge where an init or update executes, no step is applied and `tick_o` is low in the following cycle.
- R11: A pulse on `addend_set_i` raises `addend_pending_o`. One edge later the trim word is copied from `addend_i` and the flag clears. Changing `addend_i` without this command does not change the step rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Global counting enable |
| fine_i | input | 1 | 1 = accumulator-gated steps, 0 = step every clock |
| sub_inc_i | input | INC_W | Nanoseconds added per step |
| addend_i | input | ACC_W | Trim word, captured by the trim-load command |
| shadow_sec_i | input | SEC_W | Shadow seconds for init and update |
| shadow_ns_i | input | 32 | Shadow nanoseconds; bit 31 = subtract on update |
| init_set_i | input | 1 | Request time load |
| update_set_i | input | 1 | Request offset add/subtract |
| addend_set_i | input | 1 | Request trim word load |
| init_pending_o | output | 1 | Time load requested, not yet done |
| update_pending_o | output | 1 | Offset update requested, not yet done |
| addend_pending_o | output | 1 | Trim load requested, not yet done |
| sec_o | output | SEC_W | Current seconds |
| ns_o | output | 30 | Current nanoseconds |
| tick_o | output | 1 | High for one cycle after each applied step |

## Verification
Two collisions are checked. In the first, init and update are requested in the same cycle with counting stopped. The bench checks that after the first execution edge the shadow time has been loaded and update is still pending. After the second edge it checks that the offset has been added to the loaded value and not to the old time. In the second, an init is executed while coarse counting runs. The bench checks that the load edge applies no step: the output equals the shadow time exactly and the strobe is low.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
   localparam int unsigned NS_PER_SEC = 1_000_000_000;
   localparam int NS_W   = 30;
   localparam int WORD_W = 32;
   localparam int SIGN_BIT = 31;
   localparam int N_CMD = 3;
   localparam int CMD_INIT = 0;
   localparam int CMD_UPD  = 1;
   localparam int CMD_TRIM = 2;
endpackage

// File: rtl/ptp_tod_cmd.sv
module ptp_tod_cmd
   import ptp_tod_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_CMD-1:0] set_i,
   output logic [N_CMD-1:0] pending_o,
   output logic [N_CMD-1:0] go_o
);
   logic [N_CMD-1:0] pend_q;
   logic [N_CMD-1:0] blocked;

   // a time load outranks an offset update; the trim load never waits
   always_comb begin
      blocked           = '0;
      blocked[CMD_UPD]  = pend_q[CMD_INIT];
   end

   for (genvar i = 0; i < N_CMD; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)          pend_q[i] <= 1'b0;
         else if (pend_q[i])  pend_q[i] <= blocked[i];
         else                 pend_q[i] <= set_i[i];
      end
      assign go_o[i] = pend_q[i] & ~blocked[i];
   end

   assign pending_o = pend_q;
endmodule

// File: rtl/ptp_tod_rate.sv
module ptp_tod_rate #(
   parameter int ACC_W    = 32,
   parameter bit HAS_FINE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable_i,
   input  logic             fine_i,
   input  logic             load_i,
   input  logic [ACC_W-1:0] addend_i,
   output logic             step_o
);
   if (HAS_FINE) begin : g_fine
      logic [ACC_W-1:0] trim_q;
      logic [ACC_W-1:0] acc_q;
      logic [ACC_W:0]   acc_sum;

      assign acc_sum = {1'b0, acc_q} + {1'b0, trim_q};

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            trim_q <= '0;
            acc_q  <= '0;
         end else begin
            if (load_i)              trim_q <= addend_i;
            if (enable_i && fine_i)  acc_q  <= acc_sum[ACC_W-1:0];
         end
      end

      assign step_o = enable_i & (fine_i ? acc_sum[ACC_W] : 1'b1);
   end else begin : g_coarse_only
      logic unused_in;
      assign unused_in = fine_i ^ load_i ^ (^addend_i) ^ clk ^ rst_n;
      assign step_o    = enable_i;
   end
endmodule

// File: rtl/ptp_tod_time.sv
module ptp_tod_time
   import ptp_tod_pkg::*;
#(
   parameter int SEC_W = 48,
   parameter int INC_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   input  logic              init_go_i,
   input  logic              upd_go_i,
   input  logic [INC_W-1:0]  inc_i,
   input  logic [SEC_W-1:0]  sh_sec_i,
   input  logic [WORD_W-1:0] sh_ns_i,
   output logic [SEC_W-1:0]  sec_o,
   output logic [NS_W-1:0]   ns_o,
   output logic              tick_o
);
   localparam logic [WORD_W-1:0] WRAP = WORD_W'(NS_PER_SEC);

   logic [SEC_W-1:0] sec_q;
   logic [NS_W-1:0]  ns_q;
   logic             tick_q;

   logic [WORD_W-1:0] inc_sum, upd_sum;
   logic              inc_wrap, upd_ge, sub_mode;
   logic [NS_W-1:0]   inc_ns, upd_ns;
   logic [SEC_W-1:0]  upd_sec;

   always_comb begin
      inc_sum  = WORD_W'(ns_q) + WORD_W'(inc_i);
      inc_wrap = inc_sum >= WRAP;
      inc_ns   = NS_W'(inc_wrap ? inc_sum - WRAP : inc_sum);

      sub_mode = sh_ns_i[SIGN_BIT];
      upd_sum  = WORD_W'(ns_q) + {1'b0, sh_ns_i[SIGN_BIT-1:0]};
      upd_ge   = upd_sum >= WRAP;
      upd_ns   = NS_W'(upd_ge ? upd_sum - WRAP : upd_sum);
      if (sub_mode) upd_sec = sec_q - sh_sec_i - SEC_W'(!upd_ge);
      else          upd_sec = sec_q + sh_sec_i + SEC_W'(upd_ge);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_q  <= '0;
         ns_q   <= '0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= step_i & ~init_go_i & ~upd_go_i;
         if (init_go_i) begin
            sec_q <= sh_sec_i;
            ns_q  <= sh_ns_i[NS_W-1:0];
         end else if (upd_go_i) begin
            sec_q <= upd_sec;
            ns_q  <= upd_ns;
         end else if (step_i) begin
            ns_q <= inc_ns;
            if (inc_wrap) sec_q <= sec_q + 1'b1;
         end
      end
   end

   assign sec_o  = sec_q;
   assign ns_o   = ns_q;
   assign tick_o = tick_q;
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
   import ptp_tod_pkg::*;
#(
   parameter int SEC_W    = 48,
   parameter int INC_W    = 8,
   parameter int ACC_W    = 32,
   parameter bit HAS_FINE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic              fine_i,
   input  logic [INC_W-1:0]  sub_inc_i,
   input  logic [ACC_W-1:0]  addend_i,
   input  logic [SEC_W-1:0]  shadow_sec_i,
   input  logic [31:0]       shadow_ns_i,
   input  logic              init_set_i,
   input  logic              update_set_i,
   input  logic              addend_set_i,
   output logic              init_pending_o,
   output logic              update_pending_o,
   output logic              addend_pending_o,
   output logic [SEC_W-1:0]  sec_o,
   output logic [29:0]       ns_o,
   output logic              tick_o
);
   if (INC_W < 1 || INC_W > NS_W) begin : g_bad_inc
      $error("ptp_tod_counter: INC_W out of range");
   end
   if (ACC_W < 2) begin : g_bad_acc
      $error("ptp_tod_counter: ACC_W too small");
   end
   if (SEC_W < 1) begin : g_bad_sec
      $error("ptp_tod_counter: SEC_W too small");
   end

   logic [N_CMD-1:0] cmd_set, cmd_pend, cmd_go;
   logic             step;

   always_comb begin
      cmd_set           = '0;
      cmd_set[CMD_INIT] = init_set_i;
      cmd_set[CMD_UPD]  = update_set_i;
      cmd_set[CMD_TRIM] = addend_set_i;
   end

   ptp_tod_cmd u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (cmd_set),
      .pending_o (cmd_pend),
      .go_o      (cmd_go)
   );

   ptp_tod_rate #(.ACC_W(ACC_W), .HAS_FINE(HAS_FINE)) u_rate (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (enable_i),
      .fine_i   (fine_i),
      .load_i   (cmd_go[CMD_TRIM]),
      .addend_i (addend_i),
      .step_o   (step)
   );

   ptp_tod_time #(.SEC_W(SEC_W), .INC_W(INC_W)) u_time (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_i    (step),
      .init_go_i (cmd_go[CMD_INIT]),
      .upd_go_i  (cmd_go[CMD_UPD]),
      .inc_i     (sub_inc_i),
      .sh_sec_i  (shadow_sec_i),
      .sh_ns_i   (shadow_ns_i),
      .sec_o     (sec_o),
      .ns_o      (ns_o),
      .tick_o    (tick_o)
   );

   assign init_pending_o   = cmd_pend[CMD_INIT];
   assign update_pending_o = cmd_pend[CMD_UPD];
   assign addend_pending_o = cmd_pend[CMD_TRIM];
endmodule

// File: rtl/ptp_tod_counter_chk.sv
module ptp_tod_counter_chk #(
   parameter int SEC_W = 48
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable_i,
   input logic             fine_i,
   input logic             init_pending_o,
   input logic             update_pending_o,
   input logic             addend_pending_o,
   input logic [SEC_W-1:0] sec_o,
   input logic [29:0]      ns_o,
   input logic             tick_o
);
   p_ns_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ns_o < 30'd1_000_000_000);

   p_coarse_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && enable_i && !fine_i && !init_pending_o && !update_pending_o) |-> tick_o);

   p_idle_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && !enable_i) |-> !tick_o);

   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && !enable_i && !init_pending_o && !update_pending_o)
         |-> ($stable(ns_o) && $stable(sec_o)));

   p_init_selfclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      init_pending_o |=> !init_pending_o);

   p_init_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (init_pending_o && update_pending_o) |=> update_pending_o);

   p_cmd_no_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (init_pending_o || update_pending_o) |=> !tick_o);

   p_trim_selfclear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      addend_pending_o |=> !addend_pending_o);
endmodule

bind ptp_tod_counter ptp_tod_counter_chk #(.SEC_W(SEC_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .enable_i         (enable_i),
   .fine_i           (fine_i),
   .init_pending_o   (init_pending_o),
   .update_pending_o (update_pending_o),
   .addend_pending_o (addend_pending_o),
   .sec_o            (sec_o),
   .ns_o             (ns_o),
   .tick_o           (tick_o)
);

// File: tb/ptp_tod_counter_test.sv
module ptp_tod_counter_test;
   localparam int SEC_W = 48;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              enable_i = 1'b0, fine_i = 1'b0;
   logic [7:0]        sub_inc_i = '0;
   logic [31:0]       addend_i = '0;
   logic [SEC_W-1:0]  shadow_sec_i = '0;
   logic [31:0]       shadow_ns_i = '0;
   logic              init_set_i = 1'b0, update_set_i = 1'b0, addend_set_i = 1'b0;
   logic              init_pending_o, update_pending_o, addend_pending_o;
   logic [SEC_W-1:0]  sec_o;
   logic [29:0]       ns_o;
   logic              tick_o;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   ptp_tod_counter #(.SEC_W(SEC_W)) uut (
      .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .fine_i(fine_i),
      .sub_inc_i(sub_inc_i), .addend_i(addend_i), .shadow_sec_i(shadow_sec_i),
      .shadow_ns_i(shadow_ns_i), .init_set_i(init_set_i), .update_set_i(update_set_i),
      .addend_set_i(addend_set_i), .init_pending_o(init_pending_o),
      .update_pending_o(update_pending_o), .addend_pending_o(addend_pending_o),
      .sec_o(sec_o), .ns_o(ns_o), .tick_o(tick_o)
   );

   // coarse-mode vectors: start time, step, edge count, expected time
   localparam int NV = 5;
   localparam longint V_SEC  [NV] = '{5, 9, 0, 100, 7};
   localparam longint V_NS   [NV] = '{0, 999_999_990, 999_999_745, 123_456_789, 50};
   localparam int     V_INC  [NV] = '{10, 4, 255, 1, 0};
   localparam int     V_N    [NV] = '{7, 3, 1, 20, 5};
   localparam longint V_XSEC [NV] = '{5, 10, 1, 100, 7};
   localparam longint V_XNS  [NV] = '{70, 2, 0, 123_456_809, 50};

   task automatic chk(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load_time(input longint s, input longint ns);
      shadow_sec_i = SEC_W'(s);
      shadow_ns_i  = 32'(ns);
      init_set_i   = 1'b1;
      step(1);
      init_set_i   = 1'b0;
      step(1);
   endtask

   task automatic load_trim(input logic [31:0] a);
      addend_i     = a;
      addend_set_i = 1'b1;
      step(1);
      chk("R11 trim pending", longint'(addend_pending_o), 1);
      addend_set_i = 1'b0;
      step(1);
      chk("R11 trim pending cleared", longint'(addend_pending_o), 0);
   endtask

   task automatic do_update(input longint s, input logic [31:0] nsw);
      shadow_sec_i = SEC_W'(s);
      shadow_ns_i  = nsw;
      update_set_i = 1'b1;
      step(1);
      update_set_i = 1'b0;
      step(1);
   endtask

   task automatic count_ticks(input int n, output int cnt);
      cnt = 0;
      for (int k = 0; k < n; k++) begin
         step(1);
         if (tick_o) cnt++;
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int cnt;
      @(negedge clk);
      step(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 sec", longint'(sec_o), 0);
      chk("R1 ns", longint'(ns_o), 0);
      chk("R1 tick", longint'(tick_o), 0);
      chk("R1 pending", longint'({init_pending_o, update_pending_o, addend_pending_o}), 0);

      // R2/R3 coarse vectors
      for (int v = 0; v < NV; v++) begin
         sub_inc_i = 8'(V_INC[v]);
         init_set_i = 1'b1;
         shadow_sec_i = SEC_W'(V_SEC[v]);
         shadow_ns_i  = 32'(V_NS[v]);
         step(1);
         chk("R6 init pending", longint'(init_pending_o), 1);
         init_set_i = 1'b0;
         step(1);
         chk("R6 init cleared", longint'(init_pending_o), 0);
         chk("R6 loaded ns", longint'(ns_o), V_NS[v]);
         enable_i = 1'b1;
         step(V_N[v]);
         chk("R2 tick strobe", longint'(tick_o), 1);
         enable_i = 1'b0;
         chk("R3 sec after steps", longint'(sec_o), V_XSEC[v]);
         chk("R2 ns after steps", longint'(ns_o), V_XNS[v]);
         step(4);
         // R5 hold while disabled
         chk("R5 tick low", longint'(tick_o), 0);
         chk("R5 ns held", longint'(ns_o), V_XNS[v]);
      end

      // R7 add with carry
      load_time(10, 999_999_000);
      do_update(2, 32'd1500);
      chk("R7 sec", longint'(sec_o), 13);
      chk("R7 ns", longint'(ns_o), 500);
      // R8 subtract with borrow: 13.000000500 - 1.000000600
      do_update(1, 32'h8000_0000 | 32'(1_000_000_000 - 600));
      chk("R8 borrow sec", longint'(sec_o), 11);
      chk("R8 borrow ns", longint'(ns_o), 999_999_900);
      // R8 subtract without borrow: minus 0.000000900
      do_update(0, 32'h8000_0000 | 32'(1_000_000_000 - 900));
      chk("R8 sec", longint'(sec_o), 11);
      chk("R8 ns", longint'(ns_o), 999_999_000);

      // R9 init and update requested together
      shadow_sec_i = SEC_W'(40);
      shadow_ns_i  = 32'd1000;
      init_set_i   = 1'b1;
      update_set_i = 1'b1;
      step(1);
      init_set_i   = 1'b0;
      update_set_i = 1'b0;
      step(1);
      chk("R9 init first sec", longint'(sec_o), 40);
      chk("R9 update still pending", longint'(update_pending_o), 1);
      step(1);
      chk("R9 update on loaded sec", longint'(sec_o), 80);
      chk("R9 update on loaded ns", longint'(ns_o), 2000);
      chk("R9 update cleared", longint'(update_pending_o), 0);

      // R10 command edge applies no step while counting
      sub_inc_i = 8'd10;
      enable_i  = 1'b1;
      step(3);
      load_time(3, 0);
      chk("R10 exact load ns", longint'(ns_o), 0);
      chk("R10 no tick on load", longint'(tick_o), 0);
      step(1);
      chk("R10 counting resumes", longint'(ns_o), 10);
      enable_i = 1'b0;
      step(1);

      // R4 fine mode
      sub_inc_i = 8'd3;
      fine_i    = 1'b1;
      load_time(0, 0);
      load_trim(32'h8000_0000);
      enable_i = 1'b1;
      count_ticks(8, cnt);
      enable_i = 1'b0;
      chk("R4 half-rate ticks", longint'(cnt), 4);
      chk("R4 half-rate ns", longint'(ns_o), 12);
      step(1);
      load_trim(32'h4000_0000);
      enable_i = 1'b1;
      count_ticks(16, cnt);
      chk("R4 quarter-rate ticks", longint'(cnt), 4);
      // R11 trim input change without load has no effect
      addend_i = 32'hFFFF_FFFF;
      count_ticks(16, cnt);
      chk("R11 rate unchanged", longint'(cnt), 4);
      enable_i = 1'b0;
      step(1);
      chk("R11 ns after both windows", longint'(ns_o), 12 + 24);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule